// File: doc/BRIEF.md
# Speculative Load Conflict Tracker

This block lets a pipeline move a load ahead of older stores. When such a hoisted load issues, it records its memory word and its destination register tag in a small associative table. Every store that executes later searches the table by word address. A store that hits an entry marks that entry as spoiled.

At the spot where the load first sat in program order, a check operation carrying the same register tag asks the table whether the early value can still be trusted. One cycle later the block answers with one of two results. The pipeline either goes on, or branches to recovery code that repeats the load. Both answers release the entry. The block does no memory access and runs no recovery code.

The table has eight slots. A tag can be present in at most one slot. When a tag has been lost, whether it was evicted or never recorded, the block always answers "recover", because that answer is always safe.

Top module: `spec_ld_tracker`

## Requirements
- R1: After synchronous reset, the table is empty and both response outputs are 0, so a check for any tag answers recover.
- R2: After an allocation, a check with the same tag answers continue (chk_recover = 0) if no store to that word has been seen since.
- R3: A store whose word address equals a recorded entry's word marks that entry, and its later check answers recover (chk_recover = 1).
- R4: A store to a word that matches no recorded entry does not change any check result.
- R5: Addresses are compared as 4-byte words using bits [31:2]. Bits [1:0] are ignored, so any byte in the same word is a conflict.
- R6: A check for a tag that no valid entry holds answers recover.
- R7: A check, whatever its answer, frees the entry it matched in that cycle. A second check of the same tag therefore answers recover.
- R8: An allocation whose tag is already held overwrites that entry in place and clears its conflict mark.
- R9: An allocation with a new tag takes the lowest-numbered free slot. When all slots are full, it evicts the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on each eviction.
- R10: If an allocation and a store to the same word arrive in the same cycle, the allocation wins and its new entry is not marked.
- R11: If a store and a check arrive in the same cycle, the store is treated as older, so a word match makes that check answer recover.
- R12: chk_resp_valid is 1 exactly in the cycle after chk_valid was 1. chk_recover is 0 whenever chk_resp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | A speculative load issues this cycle |
| alloc_tag | input | 5 | Destination register tag of that load |
| alloc_addr | input | 32 | Byte address of that load |
| st_valid | input | 1 | A store executes this cycle |
| st_addr | input | 32 | Byte address of that store |
| chk_valid | input | 1 | Check request this cycle |
| chk_tag | input | 5 | Tag being checked |
| chk_resp_valid | output | 1 | Check answer is present |
| chk_recover | output | 1 | 1 = re-execute the load, 0 = continue |

## Verification
A slot that wrongly keeps its valid bit, loses its conflict mark, or holds a stale tag shows up at the ports only when its tag is next checked. The answer arrives one cycle after that check. An eviction pointer that has drifted gives a "recover" for a tag that should have survived, or a "continue" for a tag that should have been dropped, the first time the table fills. The random mix therefore uses few tags and few words, so that fills, overwrites and same-cycle collisions happen often, and each one is checked against an independent model.

// File: rtl/sldt_pkg.sv
package sldt_pkg;
    localparam int TAG_W  = 5;
    localparam int ADDR_W = 32;
    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic              vld;
        logic              viol;
        logic [TAG_W-1:0]  tag;
        logic [WORD_W-1:0] word;
    } ent_t;

    function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:2];
    endfunction
endpackage

// File: rtl/sldt_slot.sv
module sldt_slot
    import sldt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [WORD_W-1:0] wr_word,
    input  logic              free_i,
    input  logic              mark_i,
    input  logic [TAG_W-1:0]  chk_tag,
    input  logic [WORD_W-1:0] st_word,
    output ent_t              ent,
    output logic              chk_hit,
    output logic              alloc_hit,
    output logic              st_hit
);
    ent_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (wr) begin
            q.vld  <= 1'b1;
            q.viol <= 1'b0;
            q.tag  <= wr_tag;
            q.word <= wr_word;
        end else if (free_i) begin
            q.vld  <= 1'b0;
            q.viol <= 1'b0;
        end else if (mark_i) begin
            q.viol <= 1'b1;
        end
    end

    assign ent       = q;
    assign chk_hit   = q.vld && (q.tag == chk_tag);
    assign alloc_hit = q.vld && (q.tag == wr_tag);
    assign st_hit    = q.vld && (q.word == st_word);
endmodule

// File: rtl/sldt_pick.sv
module sldt_pick #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  same_tag,
    input  logic [N-1:0]  free_vec,
    input  logic [IW-1:0] rr_ptr,
    output logic [IW-1:0] idx,
    output logic          evict
);
    logic [IW-1:0] tag_idx, free_idx;

    always_comb begin
        tag_idx  = '0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (same_tag[i]) tag_idx  = IW'(i);
            if (free_vec[i]) free_idx = IW'(i);
        end
        evict = 1'b0;
        if (|same_tag)      idx = tag_idx;
        else if (|free_vec) idx = free_idx;
        else begin
            idx   = rr_ptr;
            evict = 1'b1;
        end
    end
endmodule

// File: rtl/spec_ld_tracker.sv
module spec_ld_tracker
    import sldt_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [TAG_W-1:0]  chk_tag,
    output logic              chk_resp_valid,
    output logic              chk_recover
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    ent_t               ent_q [ENTRIES];
    logic [ENTRIES-1:0] chk_hit, alloc_hit, st_hit, free_vec, viol_vec;
    logic [IDX_W-1:0]   pick_idx, rr_q;
    logic               evict;
    logic [WORD_W-1:0]  st_word, al_word;

    assign st_word = word_of(st_addr);
    assign al_word = word_of(alloc_addr);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        sldt_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr        (alloc_valid && (pick_idx == IDX_W'(g))),
            .wr_tag    (alloc_tag),
            .wr_word   (al_word),
            .free_i    (chk_valid && chk_hit[g]),
            .mark_i    (st_valid && st_hit[g]),
            .chk_tag   (chk_tag),
            .st_word   (st_word),
            .ent       (ent_q[g]),
            .chk_hit   (chk_hit[g]),
            .alloc_hit (alloc_hit[g]),
            .st_hit    (st_hit[g])
        );
        assign free_vec[g] = ~ent_q[g].vld;
        assign viol_vec[g] = ent_q[g].viol;
    end

    sldt_pick #(.N(ENTRIES), .IW(IDX_W)) u_pick (
        .same_tag (alloc_hit),
        .free_vec (free_vec),
        .rr_ptr   (rr_q),
        .idx      (pick_idx),
        .evict    (evict)
    );

    // Store in the same cycle counts as older than the check.
    logic found, conflict;
    assign found    = |chk_hit;
    assign conflict = |(chk_hit & (viol_vec | (st_valid ? st_hit : '0)));

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q           <= '0;
            chk_resp_valid <= 1'b0;
            chk_recover    <= 1'b0;
        end else begin
            if (alloc_valid && evict)
                rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
            chk_resp_valid <= chk_valid;
            chk_recover    <= chk_valid && (!found || conflict);
        end
    end
endmodule

// File: rtl/sldt_checker.sv
module sldt_checker
    import sldt_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              alloc_valid,
    input logic [TAG_W-1:0]  alloc_tag,
    input logic [ADDR_W-1:0] alloc_addr,
    input logic              chk_valid,
    input logic [TAG_W-1:0]  chk_tag,
    input logic              chk_resp_valid,
    input logic              chk_recover,
    input ent_t              ent [ENTRIES]
);
    logic              pa_v, pc_v, p_same;
    logic [TAG_W-1:0]  pa_tag, pc_tag;
    logic [WORD_W-1:0] pa_word;
    logic              alloc_ok, chk_left, dup;

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_v <= 1'b0; pc_v <= 1'b0; p_same <= 1'b0;
            pa_tag <= '0; pc_tag <= '0; pa_word <= '0;
        end else begin
            pa_v    <= alloc_valid;
            pa_tag  <= alloc_tag;
            pa_word <= word_of(alloc_addr);
            pc_v    <= chk_valid;
            pc_tag  <= chk_tag;
            p_same  <= alloc_valid && (alloc_tag == chk_tag);
        end
    end

    always_comb begin
        alloc_ok = 1'b0;
        chk_left = 1'b0;
        dup      = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent[i].vld && !ent[i].viol && ent[i].tag == pa_tag && ent[i].word == pa_word)
                alloc_ok = 1'b1;
            if (ent[i].vld && ent[i].tag == pc_tag)
                chk_left = 1'b1;
            for (int j = i + 1; j < ENTRIES; j++)
                if (ent[i].vld && ent[j].vld && ent[i].tag == ent[j].tag)
                    dup = 1'b1;
        end
    end

    p_alloc_clean_r2: assert property (@(posedge clk) disable iff (rst)
        pa_v |-> alloc_ok);
    p_check_frees_r7: assert property (@(posedge clk) disable iff (rst)
        (pc_v && !p_same) |-> !chk_left);
    p_tag_unique_r8: assert property (@(posedge clk) disable iff (rst)
        !dup);
    p_resp_follows_req_r12: assert property (@(posedge clk) disable iff (rst)
        chk_resp_valid == pc_v);
    p_recover_needs_resp_r12: assert property (@(posedge clk) disable iff (rst)
        chk_recover |-> chk_resp_valid);
endmodule

bind spec_ld_tracker sldt_checker #(.ENTRIES(ENTRIES)) u_sldt_chk (
    .clk            (clk),
    .rst            (rst),
    .alloc_valid    (alloc_valid),
    .alloc_tag      (alloc_tag),
    .alloc_addr     (alloc_addr),
    .chk_valid      (chk_valid),
    .chk_tag        (chk_tag),
    .chk_resp_valid (chk_resp_valid),
    .chk_recover    (chk_recover),
    .ent            (ent_q)
);

// File: tb/tb_spec_ld_tracker.sv
module tb_spec_ld_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_valid = 0, st_valid = 0, chk_valid = 0;
    logic [4:0]  alloc_tag = 0, chk_tag = 0;
    logic [31:0] alloc_addr = 0, st_addr = 0;
    logic        chk_resp_valid, chk_recover;

    spec_ld_tracker dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int compared = 0, mismatched = 0;

    // independent model of the table
    bit          m_vld [N];
    bit          m_viol[N];
    logic [4:0]  m_tag [N];
    logic [29:0] m_word[N];
    int          m_rr = 0;

    // expectation pending for the next sample point
    bit    e_rv = 0, e_rec = 0;
    string e_why = "R1";
    int    e_lit = -1;

    function automatic int find_tag(input logic [4:0] t);
        for (int i = 0; i < N; i++) if (m_vld[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic int pick_slot(input logic [4:0] t);
        int k;
        k = find_tag(t);
        if (k >= 0) return k;
        for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
        return -1;
    endfunction

    task automatic check(input bit act, input bit exp, input string req, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic step(input bit av, input logic [4:0] at, input logic [31:0] aa,
                        input bit sv, input logic [31:0] sa,
                        input bit cv, input logic [4:0] ct,
                        input string why, input int lit);
        int k, s;
        bit rec;
        bit nv[N];
        @(negedge clk);
        check(chk_resp_valid, e_rv, "R12", "resp_valid");
        if (e_rv) check(chk_recover, e_rec, e_why, "recover vs model");
        else      check(chk_recover, 1'b0, "R12", "recover while idle");
        if (e_lit >= 0) check(chk_recover, e_lit[0], e_why, "recover directed");
        alloc_valid = av; alloc_tag = at; alloc_addr = aa;
        st_valid = sv; st_addr = sa; chk_valid = cv; chk_tag = ct;
        e_rv = cv; e_rec = 0; e_lit = lit; e_why = why;
        k = find_tag(ct);
        if (cv) begin
            if (k < 0) begin
                e_rec = 1; if (why == "") e_why = "R6";
            end else if (sv && m_word[k] == sa[31:2]) begin
                e_rec = 1; if (why == "") e_why = "R11";
            end else begin
                e_rec = m_viol[k]; if (why == "") e_why = m_viol[k] ? "R3" : "R2";
            end
        end
        s = pick_slot(at);
        for (int i = 0; i < N; i++) nv[i] = m_vld[i];
        if (cv && k >= 0) begin nv[k] = 0; m_viol[k] = 0; end
        if (sv) for (int i = 0; i < N; i++)
            if (m_vld[i] && !(cv && i == k) && m_word[i] == sa[31:2]) m_viol[i] = 1;
        if (av) begin
            if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % N; end
            nv[s] = 1; m_viol[s] = 0; m_tag[s] = at; m_word[s] = aa[31:2];
        end
        for (int i = 0; i < N; i++) m_vld[i] = nv[i];
    endtask

    task automatic ld(input logic [4:0] t, input logic [31:0] a, input string w);
        step(1, t, a, 0, 0, 0, 0, w, -1);
    endtask
    task automatic st(input logic [31:0] a, input string w);
        step(0, 0, 0, 1, a, 0, 0, w, -1);
    endtask
    task automatic ck(input logic [4:0] t, input int want, input string w);
        step(0, 0, 0, 0, 0, 1, t, w, want);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1357);
        for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_viol[i] = 0; m_tag[i] = 0; m_word[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(chk_resp_valid, 1'b0, "R1", "reset resp_valid");
        check(chk_recover, 1'b0, "R1", "reset recover");
        ck(5'd3, 1, "R1");
        ld(5'd1, 32'h100, "R2");          ck(5'd1, 0, "R2");
        ld(5'd2, 32'h200, "R3"); st(32'h200, "R3"); ck(5'd2, 1, "R3");
        ld(5'd3, 32'h300, "R4"); st(32'h304, "R4"); ck(5'd3, 0, "R4");
        ld(5'd4, 32'h400, "R5"); st(32'h403, "R5"); ck(5'd4, 1, "R5");
        ld(5'd5, 32'h500, "R7"); ck(5'd5, 0, "R7"); ck(5'd5, 1, "R7");
        ld(5'd6, 32'h600, "R8"); st(32'h600, "R8"); ld(5'd6, 32'h700, "R8"); ck(5'd6, 0, "R8");
        step(1, 5'd7, 32'h800, 1, 32'h802, 0, 0, "R10", -1); ck(5'd7, 0, "R10");
        ld(5'd8, 32'h900, "R11"); step(0, 0, 0, 1, 32'h901, 1, 5'd8, "R11", 1);
        ck(5'd9, 1, "R6");
        for (int i = 0; i < N; i++) ld(5'(10 + i), 32'h1000 + 32'(i) * 16, "R9");
        ld(5'd18, 32'h2000, "R9"); ld(5'd19, 32'h2010, "R9");
        ck(5'd10, 1, "R9"); ck(5'd11, 1, "R9"); ck(5'd12, 0, "R9");
        ck(5'd18, 0, "R9"); ck(5'd19, 0, "R9");
        for (int i = 13; i < 18; i++) ck(5'(i), 0, "R9");
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 1), 5'($urandom_range(0, 11)), 32'($urandom_range(0, 23)),
                 ($urandom_range(0, 2) == 0), 32'($urandom_range(0, 23)),
                 $urandom_range(0, 1), 5'($urandom_range(0, 11)), "", -1);
        end
        step(0, 0, 0, 0, 0, 0, 0, "", -1);
        step(0, 0, 0, 0, 0, 0, 0, "", -1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule